// File: doc/BRIEF.md
# Priority Reference Source Selector

This block chooses which of fourteen reference clock inputs drives a timing loop. Every input carries a qualification flag from an outside monitor and a programmable 4-bit priority. In automatic mode the selector picks the best qualified input, where a lower nonzero priority value is better. A priority of zero keeps an input out of the choice. When several qualified inputs share the best priority, the one that has been qualified longest wins. An input that drops out and comes back goes to the end of its group, so its return does not move the selection.

A 4-bit force field overrides the automatic choice. A value from 1 to 14 selects that input outright. Zero, and the unused code 15, leave the choice to the automatic logic. The automatic logic works only while its enable input is high. When nothing can be selected, a no-source flag rises and the last index is held, so the loop downstream can go to holdover. All configuration comes in as plain ports. The index and the flag are registered.

Top module: `ref_selector`

## Requirements
- R1: An input whose priority field is 0 is never picked in automatic mode. Among qualified inputs with nonzero priority, the lowest priority value wins. Inputs are numbered 1 to 14, and bit k-1 of the valid and priority buses belongs to input k.
- R2: A force value n in 1..14 sets the index output to n and drops the no-source flag, whatever the valid flags and priorities are.
- R3: A force value of 0 or 15 leaves the choice to the automatic logic.
- R4: With force 0 and the automatic enable low, the no-source flag is high and the index keeps its previous value.
- R5: Selection is revertive. Once a qualified input has a strictly better priority than the current one, it is selected.
- R6: When the selected input loses its valid flag, the best remaining qualified input is selected.
- R7: Among qualified inputs of equal priority, the earliest qualified wins. An input that requalifies is placed behind those already qualified and causes no switch.
- R8: Equal-priority inputs that qualify in the same cycle are ordered by ascending input number.
- R9: In automatic mode with no qualified nonzero-priority input, the no-source flag is high and the last index is held.
- R10: Outputs reflect the inputs sampled at the previous rising clock edge. There is exactly one cycle of latency.
- R11: Reset sets the index to 0 and the no-source flag to 1, and it erases all qualification-order history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid_i | input | 14 | Qualification flag per input, bit k-1 for input k |
| ref_prio_i | input | 56 | Priority per input, 4 bits each, bits [4k-1:4k-4] for input k |
| force_sel_i | input | 4 | Force field: 1..14 forces that input, 0 or 15 means automatic |
| auto_en_i | input | 1 | Enables automatic selection |
| sel_idx_o | output | 4 | Selected input number, 0 only after reset |
| no_ref_o | output | 1 | High when no input is selected |

## Verification
The hardest state to reach is a group of several qualified inputs with the same priority whose order of qualification differs from their index order. Reaching it takes inputs that drop out and requalify while their peers stay valid. Directed steps build this case: one input falls and returns behind its peer, two inputs rise in the same cycle, and a reset is applied after a reordered history to show the order is cleared. The random phase draws priorities from only four values and toggles each valid flag at a low rate. This keeps equal-priority groups populated and their arrival order shuffled over thousands of cycles. A bench model that timestamps every arrival predicts each result.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;
  localparam int unsigned NUM_REF_DEF = 14;
  localparam int unsigned PRIO_W_DEF  = 4;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_FORCED = 2'd1,
    MODE_AUTO   = 2'd2
  } sel_mode_e;
endpackage

// File: rtl/ref_rst_sync.sv
module ref_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/ref_arrival_order.sv
// Keeps a pairwise "qualified earlier" matrix among the inputs.
// ahead[i][j] = 1 means input i joined before input j.
module ref_arrival_order #(
  parameter int unsigned N_REF = 14
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_REF-1:0]            valid_i,
  output logic [N_REF-1:0][N_REF-1:0] ahead_nxt_o
);
  logic [N_REF-1:0]            valid_q;
  logic [N_REF-1:0][N_REF-1:0] ahead_q;
  logic [N_REF-1:0]            rise;
  logic                        upd_en;

  assign rise   = valid_i & ~valid_q;
  assign upd_en = |(valid_i ^ valid_q);

  always_comb begin
    for (int i = 0; i < int'(N_REF); i++) begin
      for (int j = 0; j < int'(N_REF); j++) begin
        if (i == j)                  ahead_nxt_o[i][j] = 1'b0;
        else if (rise[i] && rise[j]) ahead_nxt_o[i][j] = (i < j);
        else if (rise[j])            ahead_nxt_o[i][j] = 1'b1;
        else if (rise[i])            ahead_nxt_o[i][j] = 1'b0;
        else                         ahead_nxt_o[i][j] = ahead_q[i][j];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ahead_q <= '0;
    end else if (upd_en) begin
      valid_q <= valid_i;
      ahead_q <= ahead_nxt_o;
    end
  end
endmodule

// File: rtl/ref_priority_pick.sv
// Finds the eligible input that beats every other on (priority, arrival).
module ref_priority_pick #(
  parameter int unsigned N_REF  = 14,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned IDX_W  = $clog2(N_REF + 1)
) (
  input  logic [N_REF-1:0]             elig_i,
  input  logic [N_REF-1:0][PRIO_W-1:0] prio_i,
  input  logic [N_REF-1:0][N_REF-1:0]  ahead_i,
  output logic                         any_o,
  output logic [IDX_W-1:0]             idx_o
);
  logic [N_REF-1:0] win;

  for (genvar gi = 0; gi < int'(N_REF); gi++) begin : g_cand
    logic beats;
    always_comb begin
      beats = elig_i[gi];
      for (int j = 0; j < int'(N_REF); j++) begin
        if (j != gi && elig_i[j]) begin
          if (prio_i[j] < prio_i[gi])
            beats = 1'b0;
          else if (prio_i[j] == prio_i[gi] && !ahead_i[gi][j])
            beats = 1'b0;
        end
      end
    end
    assign win[gi] = beats;
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < int'(N_REF); i++)
      if (win[i]) idx_o = idx_o | IDX_W'(i + 1);
  end

  assign any_o = |win;
endmodule

// File: rtl/ref_selector.sv
module ref_selector #(
  parameter int unsigned N_REF  = ref_sel_pkg::NUM_REF_DEF,
  parameter int unsigned PRIO_W = ref_sel_pkg::PRIO_W_DEF,
  parameter int unsigned IDX_W  = $clog2(N_REF + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_REF-1:0]          ref_valid_i,
  input  logic [N_REF*PRIO_W-1:0]   ref_prio_i,
  input  logic [IDX_W-1:0]          force_sel_i,
  input  logic                      auto_en_i,
  output logic [IDX_W-1:0]          sel_idx_o,
  output logic                      no_ref_o
);
  import ref_sel_pkg::*;

  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(N_REF);

  logic                         rst_sync_n;
  logic [N_REF-1:0][PRIO_W-1:0] prio_arr;
  logic [N_REF-1:0]             elig;
  logic [N_REF-1:0][N_REF-1:0]  ahead_nxt;
  logic                         pick_any;
  logic [IDX_W-1:0]             pick_idx;
  sel_mode_e                    mode;
  logic [IDX_W-1:0]             sel_nxt, sel_q;
  logic                         nr_nxt, nr_q;
  logic                         out_en;

  ref_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign prio_arr = ref_prio_i;

  always_comb begin
    for (int i = 0; i < int'(N_REF); i++)
      elig[i] = ref_valid_i[i] && (prio_arr[i] != '0);
  end

  ref_arrival_order #(.N_REF(N_REF)) i_order (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .valid_i     (ref_valid_i),
    .ahead_nxt_o (ahead_nxt)
  );

  ref_priority_pick #(.N_REF(N_REF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) i_pick (
    .elig_i  (elig),
    .prio_i  (prio_arr),
    .ahead_i (ahead_nxt),
    .any_o   (pick_any),
    .idx_o   (pick_idx)
  );

  always_comb begin
    if (force_sel_i != '0 && force_sel_i <= MAX_IDX) mode = MODE_FORCED;
    else if (auto_en_i)                              mode = MODE_AUTO;
    else                                             mode = MODE_IDLE;
  end

  always_comb begin
    sel_nxt = sel_q;
    nr_nxt  = 1'b1;
    unique case (mode)
      MODE_FORCED: begin
        sel_nxt = force_sel_i;
        nr_nxt  = 1'b0;
      end
      MODE_AUTO: begin
        if (pick_any) begin
          sel_nxt = pick_idx;
          nr_nxt  = 1'b0;
        end
      end
      default: ;
    endcase
  end

  assign out_en = (sel_nxt != sel_q) || (nr_nxt != nr_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q <= '0;
      nr_q  <= 1'b1;
    end else if (out_en) begin
      sel_q <= sel_nxt;
      nr_q  <= nr_nxt;
    end
  end

  assign sel_idx_o = sel_q;
  assign no_ref_o  = nr_q;
endmodule

// File: rtl/ref_selector_chk.sv
module ref_selector_chk #(
  parameter int unsigned N_REF  = 14,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned IDX_W  = $clog2(N_REF + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_REF-1:0]        ref_valid_i,
  input logic [N_REF*PRIO_W-1:0] ref_prio_i,
  input logic [IDX_W-1:0]        force_sel_i,
  input logic                    auto_en_i,
  input logic [IDX_W-1:0]        sel_idx_o,
  input logic                    no_ref_o
);
  logic [N_REF-1:0]             v_q;
  logic [N_REF-1:0][PRIO_W-1:0] p_q;
  logic [IDX_W-1:0]             f_q;
  logic                         a_q;
  logic                         forced_q;
  logic                         any_q;
  logic [PRIO_W-1:0]            min_q;
  logic                         sel_ok;
  logic [PRIO_W-1:0]            sel_prio;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      p_q <= '0;
      f_q <= '0;
      a_q <= 1'b0;
    end else begin
      v_q <= ref_valid_i;
      p_q <= ref_prio_i;
      f_q <= force_sel_i;
      a_q <= auto_en_i;
    end
  end

  always_comb begin
    forced_q = (f_q != '0) && (int'(f_q) <= int'(N_REF));
    any_q    = 1'b0;
    min_q    = '1;
    for (int i = 0; i < int'(N_REF); i++) begin
      if (v_q[i] && p_q[i] != '0) begin
        any_q = 1'b1;
        if (p_q[i] < min_q) min_q = p_q[i];
      end
    end
    sel_ok   = 1'b0;
    sel_prio = '0;
    for (int i = 0; i < int'(N_REF); i++) begin
      if (int'(sel_idx_o) == i + 1) begin
        sel_ok   = v_q[i] && (p_q[i] != '0);
        sel_prio = p_q[i];
      end
    end
  end

  assert_forced_pick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    forced_q |-> (sel_idx_o == f_q && !no_ref_o));

  assert_hold_on_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
    no_ref_o |-> $stable(sel_idx_o));

  assert_auto_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!forced_q && !no_ref_o) |-> sel_ok);

  assert_best_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!forced_q && !no_ref_o) |-> (sel_prio == min_q));

  assert_none_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!forced_q && (!a_q || !any_q)) |-> no_ref_o);

  assert_flag_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!forced_q && a_q && any_q) |-> !no_ref_o);
endmodule

bind ref_selector ref_selector_chk #(.N_REF(N_REF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .ref_valid_i (ref_valid_i),
  .ref_prio_i  (ref_prio_i),
  .force_sel_i (force_sel_i),
  .auto_en_i   (auto_en_i),
  .sel_idx_o   (sel_idx_o),
  .no_ref_o    (no_ref_o)
);

// File: tb/test_ref_selector.sv
module test_ref_selector;
  localparam int N      = 14;
  localparam int PW     = 4;
  localparam int IW     = 4;
  localparam int CLK_P  = 10;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    valid;
  logic [N*PW-1:0] prio;
  logic [IW-1:0]   force_sel;
  logic            auto_en;
  logic [IW-1:0]   sel_idx;
  logic            no_ref;

  int vectors = 0;
  int errors  = 0;

  bit [N-1:0]  m_vprev;
  longint      m_ts [N];
  longint      m_step;
  logic [IW-1:0] m_sel;
  logic        m_nr;

  always #(CLK_P/2) clk = ~clk;

  ref_selector i_ref_selector (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_valid_i (valid),
    .ref_prio_i  (prio),
    .force_sel_i (force_sel),
    .auto_en_i   (auto_en),
    .sel_idx_o   (sel_idx),
    .no_ref_o    (no_ref)
  );

  function automatic logic [PW-1:0] prio_of(int k);
    return prio[k*PW +: PW];
  endfunction

  // Model update for inputs applied now; result visible after next edge.
  task automatic model_step();
    int best;
    m_step++;
    for (int k = 0; k < N; k++)
      if (valid[k] && !m_vprev[k]) m_ts[k] = m_step * 32 + k;
    m_vprev = valid;
    if (force_sel != 0 && force_sel <= N) begin
      m_sel = force_sel;
      m_nr  = 1'b0;
    end else if (auto_en) begin
      best = -1;
      for (int k = 0; k < N; k++) begin
        if (valid[k] && prio_of(k) != 0) begin
          if (best < 0 || prio_of(k) < prio_of(best) ||
              (prio_of(k) == prio_of(best) && m_ts[k] < m_ts[best]))
            best = k;
        end
      end
      if (best >= 0) begin
        m_sel = IW'(best + 1);
        m_nr  = 1'b0;
      end else m_nr = 1'b1;
    end else m_nr = 1'b1;
  endtask

  task automatic check(string tag, logic [IW-1:0] es, logic en);
    vectors++;
    if (sel_idx !== es || no_ref !== en) begin
      errors++;
      $display("FAIL %s: sel=%0d no_ref=%0b expected sel=%0d no_ref=%0b",
               tag, sel_idx, no_ref, es, en);
    end
  endtask

  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(tag, m_sel, m_nr);
  endtask

  task automatic set_prio(int inp, int p);
    prio[(inp-1)*PW +: PW] = PW'(p);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    check("R11 reset state", 4'd0, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_vprev = '0;
    m_sel   = '0;
    m_nr    = 1'b1;
    check("R11 after release", 4'd0, 1'b1);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL R10 watchdog expired: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_step = 0;
    for (int k = 0; k < N; k++) m_ts[k] = 0;
    valid = '0; prio = '0; force_sel = '0; auto_en = 1'b1;
    @(negedge clk);
    do_reset();

    set_prio(1, 5); set_prio(2, 5); set_prio(3, 3);
    set_prio(4, 7); set_prio(5, 7); set_prio(6, 0);
    valid[0] = 1'b1;              step("R1 single input");
    check("R1 expect 1", 4'd1, 1'b0);
    valid[1] = 1'b1;              step("R7 peer joins");
    check("R7 stay 1", 4'd1, 1'b0);
    valid[0] = 1'b0;              step("R6 fail over");
    check("R6 expect 2", 4'd2, 1'b0);
    valid[0] = 1'b1;              step("R7 recover behind");
    check("R7 no switch", 4'd2, 1'b0);
    valid[2] = 1'b1;              step("R5 revert up");
    check("R5 expect 3", 4'd3, 1'b0);
    valid[2] = 1'b0;              step("R6 back to group");
    check("R6 expect 2 again", 4'd2, 1'b0);
    valid[0] = 1'b0; valid[1] = 1'b0; valid[5] = 1'b1;
    step("R9 none eligible");
    check("R1 R9 prio0 ignored hold", 4'd2, 1'b1);
    valid[3] = 1'b1; valid[4] = 1'b1; step("R8 same cycle");
    check("R8 lower index first", 4'd4, 1'b0);
    valid[3] = 1'b0;              step("R6 drop 4");
    valid[3] = 1'b1;              step("R7 requalify 4");
    check("R7 stays 5", 4'd5, 1'b0);
    force_sel = 4'd9;             step("R2 force invalid input");
    check("R2 expect 9", 4'd9, 1'b0);
    force_sel = 4'd15;            step("R3 code 15 automatic");
    check("R3 expect 5", 4'd5, 1'b0);
    force_sel = 4'd0; auto_en = 1'b0; step("R4 auto disabled");
    check("R4 hold 5", 4'd5, 1'b1);
    auto_en = 1'b1; valid[2] = 1'b1;
    model_step();
    #1;
    check("R10 not before edge", 4'd5, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R10 one cycle later", 4'd3, 1'b0);

    // History now has 2 behind 1 removed; build 2 ahead of 1 then reset.
    valid = '0; step("R11 clear inputs");
    valid[1] = 1'b1; step("R11 history 2");
    valid[0] = 1'b1; step("R11 history 1");
    check("R11 pre-reset order", 4'd2, 1'b0);
    valid = '0;
    do_reset();
    valid[0] = 1'b1; valid[1] = 1'b1; step("R11 order cleared");
    check("R11 expect 1", 4'd1, 1'b0);

    for (int s = 0; s < 4000; s++) begin
      for (int k = 0; k < N; k++) begin
        if ($urandom % 10 == 0) valid[k] = ~valid[k];
        if ($urandom % 50 == 0) prio[k*PW +: PW] = PW'($urandom % 4);
      end
      force_sel = ($urandom % 20 == 0) ? IW'($urandom % 16) : 4'd0;
      auto_en   = ($urandom % 30 != 0);
      step("R7 R9 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule